// File: doc/BRIEF.md
# Four-Way Cache Tag Directory with Tree Pseudo-LRU

This block keeps the tags, per-line valid bits and replacement state for a 4-way set-associative cache of 128 sets with 16-byte lines, 8 KB in total. A lookup port takes an address and, one cycle later, reports whether it hit and which way holds the line. On a miss it reports the way a refill would use. When allocation is requested, the missing line is installed in that way in the same cycle. Every hit or fill updates a 3-bit tree pseudo-LRU state for the set. The block holds no data array.

A diagnostic command port gives software direct access to the per-set state. Software selects a set and a way. It can stage a tag and valid bit in a fill buffer, commit the buffer to an entry, or capture an entry's tag, valid bits and replacement bits into a read buffer. It can also invalidate the whole directory in a single cycle. The read buffer drives the diagnostic output pins at all times.

Top module: `tagdir_top`

## Requirements
- R1: The lookup address splits into tag = addr[31:11], set = addr[10:4] and offset = addr[3:0], and the offset has no effect. A lookup accepted at a clock edge raises rsp_valid_o for exactly the following cycle, carrying rsp_hit_o and rsp_way_o.
- R2: A lookup hits when a valid way of the selected set holds the same tag. rsp_way_o is then that way, or the lowest-numbered such way if several match.
- R3: On a miss, rsp_way_o is the fill way. When lk_alloc_i is 1, the tag is written to that way and its valid bit is set. When lk_alloc_i is 0, a miss changes no state.
- R4: The fill way is the lowest-numbered invalid way of the set. If all four ways are valid, it comes from the replacement bits: when bit 0 is 0 the way is {0, bit 1}, otherwise the way is {1, bit 2}.
- R5: A hit or a fill to way w sets replacement bit 0 to the inverse of w[1]. It sets bit 1 (when w < 2) or bit 2 (when w >= 2) to the inverse of w[0]. The remaining bit keeps its value.
- R6: Diagnostic op code 2'b00 loads dg_tag_i and dg_vbit_i into the fill buffer and leaves the diagnostic outputs unchanged.
- R7: Op code 2'b01 copies the fill buffer into the tag and valid bit of the selected set and way. dg_lru_i is ignored, and no diagnostic command changes replacement state, except a flush.
- R8: Op code 2'b10 loads the read buffer on the next edge with the selected way's tag (dg_tag_o) and valid bit (dg_vsel_o), the set's four valid bits (dg_vset_o, bit i = way i) and its three replacement bits (dg_lru_o).
- R9: Op code 2'b11 clears every valid bit and every replacement bit in one cycle.
- R10: When dg_valid_i and lk_valid_i are both high, the lookup is dropped: no response and no state change.
- R11: After reset, no line is valid, all replacement bits are 0, and rsp_valid_o and all diagnostic outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup address |
| lk_alloc_i | input | 1 | Install the line on a miss |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_way_o | output | 2 | Hit way, or fill way on a miss |
| dg_valid_i | input | 1 | Diagnostic command strobe |
| dg_op_i | input | 2 | Diagnostic op code |
| dg_set_i | input | 7 | Diagnostic set select |
| dg_way_i | input | 2 | Diagnostic way select |
| dg_tag_i | input | 21 | Tag to stage in the fill buffer |
| dg_vbit_i | input | 1 | Valid bit to stage in the fill buffer |
| dg_lru_i | input | 3 | Replacement bits supplied by software (ignored) |
| dg_tag_o | output | 21 | Read buffer: tag |
| dg_vsel_o | output | 1 | Read buffer: valid bit of selected way |
| dg_vset_o | output | 4 | Read buffer: valid bits of the set |
| dg_lru_o | output | 3 | Read buffer: replacement bits of the set |

## Verification
The assertions check the following on every cycle:
- Replacement state always moves away from the way just accessed.
- A fill never evicts a valid line while an invalid way exists.
- A fill leaves its way valid.
- A flush leaves all valid and replacement bits at zero.
- Non-flush diagnostic commands never touch replacement state.
- Lookups and responses pair up one-for-one, except when a diagnostic command takes the cycle.

Only the bench scenarios can show the rest:
- The exact victim sequence across several refills.
- Lowest-way priority among duplicate tags created through the diagnostic port.
- That the offset bits and dg_lru_i are ignored.
- The exact read-buffer contents.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 4;
  localparam int SET_W  = 7;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int LRU_W  = WAYS - 1;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [LRU_W-1:0] lru_t;

  typedef enum logic [1:0] {
    DG_BUF   = 2'b00,
    DG_WR    = 2'b01,
    DG_RD    = 2'b10,
    DG_FLUSH = 2'b11
  } dg_op_e;
endpackage

// File: rtl/tagdir_plru.sv
module tagdir_plru
  import tagdir_pkg::*;
(
  input  lru_t             lru_i,
  input  logic [WAYS-1:0]  valid_i,
  input  way_t             acc_way_i,
  output way_t             fill_way_o,
  output lru_t             lru_next_o
);
  way_t victim;
  way_t first_inv;
  logic any_inv;

  // tree walk: bit 0 picks the pair, bit 1/2 the line inside it
  assign victim = lru_i[0] ? {1'b1, lru_i[2]} : {1'b0, lru_i[1]};

  always_comb begin
    first_inv = '0;
    any_inv   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        first_inv = way_t'(w);
        any_inv   = 1'b1;
      end
    end
  end

  assign fill_way_o = any_inv ? first_inv : victim;

  always_comb begin
    lru_next_o    = lru_i;
    lru_next_o[0] = ~acc_way_i[1];
    if (!acc_way_i[1]) lru_next_o[1] = ~acc_way_i[0];
    else               lru_next_o[2] = ~acc_way_i[0];
  end
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match
  import tagdir_pkg::*;
#(
  parameter int TAG_W = 21
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output way_t                       hit_way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |eq;

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) hit_way_o = way_t'(w);
    end
  end
endmodule

// File: rtl/tagdir_diag.sv
module tagdir_diag
  import tagdir_pkg::*;
#(
  parameter int TAG_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dg_valid_i,
  input  logic [1:0]       dg_op_i,
  input  logic [TAG_W-1:0] dg_tag_i,
  input  logic             dg_vbit_i,
  output logic             wr_en_o,
  output logic             rd_en_o,
  output logic             flush_en_o,
  output logic [TAG_W-1:0] stage_tag_o,
  output logic             stage_vbit_o
);
  dg_op_e op;
  logic   buf_en;

  assign op         = dg_op_e'(dg_op_i);
  assign buf_en     = dg_valid_i && (op == DG_BUF);
  assign wr_en_o    = dg_valid_i && (op == DG_WR);
  assign rd_en_o    = dg_valid_i && (op == DG_RD);
  assign flush_en_o = dg_valid_i && (op == DG_FLUSH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_tag_o  <= '0;
      stage_vbit_o <= 1'b0;
    end else if (buf_en) begin
      stage_tag_o  <= dg_tag_i;
      stage_vbit_o <= dg_vbit_i;
    end
  end
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_OFS_W  = OFS_W,
  parameter int P_SET_W  = SET_W,
  localparam int TAG_W   = P_ADDR_W - P_SET_W - P_OFS_W,
  localparam int SETS    = 1 << P_SET_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lk_valid_i,
  input  logic [P_ADDR_W-1:0] lk_addr_i,
  input  logic                lk_alloc_i,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic [WAY_W-1:0]    rsp_way_o,
  input  logic                dg_valid_i,
  input  logic [1:0]          dg_op_i,
  input  logic [P_SET_W-1:0]  dg_set_i,
  input  logic [WAY_W-1:0]    dg_way_i,
  input  logic [TAG_W-1:0]    dg_tag_i,
  input  logic                dg_vbit_i,
  input  logic [LRU_W-1:0]    dg_lru_i,
  output logic [TAG_W-1:0]    dg_tag_o,
  output logic                dg_vsel_o,
  output logic [WAYS-1:0]     dg_vset_o,
  output logic [LRU_W-1:0]    dg_lru_o
);
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][LRU_W-1:0]           lru_q;

  logic [P_SET_W-1:0] lk_set;
  logic [TAG_W-1:0]   lk_tag;
  logic               lk_go;
  logic               hit;
  way_t               hit_way, fill_way, acc_way;
  lru_t               lru_next;
  logic               upd_en, fill_en;
  logic [WAYS-1:0]    set_valid;
  logic               dg_wr, dg_rd, dg_flush;
  logic [TAG_W-1:0]   stage_tag;
  logic               stage_vbit;
  logic               unused_bits;

  // offset bits and software-supplied replacement bits are don't-care
  assign unused_bits = ^{lk_addr_i[P_OFS_W-1:0], dg_lru_i};

  assign lk_set    = lk_addr_i[P_OFS_W +: P_SET_W];
  assign lk_tag    = lk_addr_i[P_ADDR_W-1 -: TAG_W];
  assign lk_go     = lk_valid_i && !dg_valid_i;
  assign set_valid = valid_q[lk_set];

  tagdir_match #(.TAG_W(TAG_W)) i_match (
    .tags_i    (tag_q[lk_set]),
    .valid_i   (set_valid),
    .tag_i     (lk_tag),
    .hit_o     (hit),
    .hit_way_o (hit_way)
  );

  assign acc_way = hit ? hit_way : fill_way;

  tagdir_plru i_plru (
    .lru_i      (lru_q[lk_set]),
    .valid_i    (set_valid),
    .acc_way_i  (acc_way),
    .fill_way_o (fill_way),
    .lru_next_o (lru_next)
  );

  tagdir_diag #(.TAG_W(TAG_W)) i_diag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dg_valid_i   (dg_valid_i),
    .dg_op_i      (dg_op_i),
    .dg_tag_i     (dg_tag_i),
    .dg_vbit_i    (dg_vbit_i),
    .wr_en_o      (dg_wr),
    .rd_en_o      (dg_rd),
    .flush_en_o   (dg_flush),
    .stage_tag_o  (stage_tag),
    .stage_vbit_o (stage_vbit)
  );

  assign fill_en = lk_go && !hit && lk_alloc_i;
  assign upd_en  = lk_go && (hit || lk_alloc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
    end else if (fill_en) begin
      tag_q[lk_set][fill_way] <= lk_tag;
    end else if (dg_wr) begin
      tag_q[dg_set_i][dg_way_i] <= stage_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lru_q   <= '0;
    end else if (dg_flush) begin
      valid_q <= '0;
      lru_q   <= '0;
    end else begin
      if (fill_en) valid_q[lk_set][fill_way]     <= 1'b1;
      if (dg_wr)   valid_q[dg_set_i][dg_way_i]   <= stage_vbit;
      if (upd_en)  lru_q[lk_set]                 <= lru_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
    end else begin
      rsp_valid_o <= lk_go;
      if (lk_go) begin
        rsp_hit_o <= hit;
        rsp_way_o <= acc_way;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dg_tag_o  <= '0;
      dg_vsel_o <= 1'b0;
      dg_vset_o <= '0;
      dg_lru_o  <= '0;
    end else if (dg_rd) begin
      dg_tag_o  <= tag_q[dg_set_i][dg_way_i];
      dg_vsel_o <= valid_q[dg_set_i][dg_way_i];
      dg_vset_o <= valid_q[dg_set_i];
      dg_lru_o  <= lru_q[dg_set_i];
    end
  end
endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk
  import tagdir_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int SET_W = 7
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       lk_valid_i,
  input logic                       dg_valid_i,
  input logic [1:0]                 dg_op_i,
  input logic                       rsp_valid_o,
  input logic                       upd_en,
  input logic                       fill_en,
  input logic [SET_W-1:0]           lk_set,
  input logic [WAY_W-1:0]           acc_way,
  input logic [WAY_W-1:0]           fill_way,
  input logic [WAYS-1:0]            set_valid,
  input logic [SETS-1:0][WAYS-1:0]  valid_q,
  input logic [SETS-1:0][LRU_W-1:0] lru_q
);
  function automatic way_t victim_of(lru_t l);
    return l[0] ? {1'b1, l[2]} : {1'b0, l[1]};
  endfunction

  // R1: every accepted lookup gets one response
  a_r1_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !dg_valid_i) |=> rsp_valid_o);

  a_r1_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o);

  // R10
  a_r10_diag_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dg_valid_i |=> !rsp_valid_o);

  // R5
  a_r5_plru_away: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en |=> victim_of(lru_q[$past(lk_set)]) != $past(acc_way));

  // R4
  a_r4_fill_prefers_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en && !(&set_valid)) |-> !set_valid[fill_way]);

  // R3
  a_r3_fill_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en |=> valid_q[$past(lk_set)][$past(fill_way)]);

  // R9
  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dg_valid_i && dg_op_i == 2'b11) |=> (valid_q == '0 && lru_q == '0));

  // R7
  a_r7_diag_keeps_lru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dg_valid_i && dg_op_i != 2'b11) |=> lru_q == $past(lru_q));
endmodule

bind tagdir_top tagdir_chk #(.SETS(SETS), .SET_W(P_SET_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_valid_i  (lk_valid_i),
  .dg_valid_i  (dg_valid_i),
  .dg_op_i     (dg_op_i),
  .rsp_valid_o (rsp_valid_o),
  .upd_en      (upd_en),
  .fill_en     (fill_en),
  .lk_set      (lk_set),
  .acc_way     (acc_way),
  .fill_way    (fill_way),
  .set_valid   (set_valid),
  .valid_q     (valid_q),
  .lru_q       (lru_q)
);

// File: tb/test_tagdir_top.sv
module test_tagdir_top;
  localparam int TAG_W = 21;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_addr_i = '0;
  logic        lk_alloc_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o;
  logic [1:0]  rsp_way_o;
  logic        dg_valid_i = 1'b0;
  logic [1:0]  dg_op_i = '0;
  logic [6:0]  dg_set_i = '0;
  logic [1:0]  dg_way_i = '0;
  logic [TAG_W-1:0] dg_tag_i = '0;
  logic        dg_vbit_i = 1'b0;
  logic [2:0]  dg_lru_i = '0;
  logic [TAG_W-1:0] dg_tag_o;
  logic        dg_vsel_o;
  logic [3:0]  dg_vset_o;
  logic [2:0]  dg_lru_o;

  always #10 clk = ~clk;

  tagdir_top i_tagdir_top (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_alloc_i(lk_alloc_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_way_o(rsp_way_o),
    .dg_valid_i(dg_valid_i), .dg_op_i(dg_op_i), .dg_set_i(dg_set_i),
    .dg_way_i(dg_way_i), .dg_tag_i(dg_tag_i), .dg_vbit_i(dg_vbit_i),
    .dg_lru_i(dg_lru_i), .dg_tag_o(dg_tag_o), .dg_vsel_o(dg_vsel_o),
    .dg_vset_o(dg_vset_o), .dg_lru_o(dg_lru_o)
  );

  // reference model built from the requirements
  logic [TAG_W-1:0] m_tag [128][4];
  logic [3:0]       m_vld [128];
  logic [2:0]       m_lru [128];
  logic [TAG_W-1:0] m_stage_tag;
  logic             m_stage_v;

  typedef struct {
    logic       hit;
    logic [1:0] way;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int set, input int ofs);
    return {tag[TAG_W-1:0], set[6:0], ofs[3:0]};
  endfunction

  task automatic m_touch(input int s, input logic [1:0] w);
    m_lru[s][0] = ~w[1];
    if (!w[1]) m_lru[s][1] = ~w[0];
    else       m_lru[s][2] = ~w[0];
  endtask

  task automatic lookup(input logic [31:0] a, input logic alloc, input string req);
    int s;
    logic [TAG_W-1:0] t;
    exp_t e;
    bit found;
    s = int'(a[10:4]);
    t = a[31:11];
    found = 0;
    e.way = '0;
    for (int w = 0; w < 4; w++) begin
      if (!found && m_vld[s][w] && m_tag[s][w] == t) begin
        found = 1; e.way = 2'(w);
      end
    end
    e.hit = found;
    if (found) begin
      m_touch(s, e.way);
    end else begin
      bit inv = 0;
      for (int w = 0; w < 4; w++) begin
        if (!inv && !m_vld[s][w]) begin inv = 1; e.way = 2'(w); end
      end
      if (!inv) e.way = m_lru[s][0] ? {1'b1, m_lru[s][2]} : {1'b0, m_lru[s][1]};
      if (alloc) begin
        m_tag[s][e.way] = t;
        m_vld[s][e.way] = 1'b1;
        m_touch(s, e.way);
      end
    end
    e.req = req;
    exp_q.push_back(e);
    lk_valid_i = 1'b1; lk_addr_i = a; lk_alloc_i = alloc;
    @(negedge clk);
    lk_valid_i = 1'b0; lk_alloc_i = 1'b0;
  endtask

  task automatic diag(input logic [1:0] op, input int s, input int w,
                      input int tag, input logic vb, input logic [2:0] lru);
    dg_valid_i = 1'b1; dg_op_i = op; dg_set_i = 7'(s); dg_way_i = 2'(w);
    dg_tag_i = tag[TAG_W-1:0]; dg_vbit_i = vb; dg_lru_i = lru;
    case (op)
      2'b00: begin m_stage_tag = tag[TAG_W-1:0]; m_stage_v = vb; end
      2'b01: begin m_tag[s][w] = m_stage_tag; m_vld[s][w] = m_stage_v; end
      2'b11: for (int i = 0; i < 128; i++) begin m_vld[i] = '0; m_lru[i] = '0; end
      default: ;
    endcase
    @(negedge clk);
    dg_valid_i = 1'b0;
  endtask

  task automatic read_chk(input int s, input int w, input string req);
    diag(2'b10, s, w, 0, 1'b0, 3'b000);
    chk({req, " tag"},   32'(dg_tag_o),  32'(m_tag[s][w]));
    chk({req, " vsel"},  32'(dg_vsel_o), 32'(m_vld[s][w]));
    chk({req, " vset"},  32'(dg_vset_o), 32'(m_vld[s]));
    chk({req, " lru"},   32'(dg_lru_o),  32'(m_lru[s]));
  endtask

  // monitor: pops expected responses as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni && rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R1 unexpected response actual=1 expected=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.req, " hit"}, 32'(rsp_hit_o), 32'(e.hit));
          chk({e.req, " way"}, 32'(rsp_way_o), 32'(e.way));
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_vld[i] = '0; m_lru[i] = '0;
      for (int w = 0; w < 4; w++) m_tag[i][w] = '0;
    end
    m_stage_tag = '0; m_stage_v = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid", 32'(rsp_valid_o), 0);
    chk("R11 dg_tag", 32'(dg_tag_o), 0);
    chk("R11 dg_vset", 32'(dg_vset_o), 0);
    chk("R11 dg_lru", 32'(dg_lru_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_chk(5, 0, "R11 read after reset");

    // miss without allocation leaves the set empty
    lookup(mk(32'h100, 5, 3), 1'b0, "R3 miss no alloc");
    read_chk(5, 0, "R3 no alloc state");

    // fill the set: invalid ways first, in order
    for (int k = 0; k < 4; k++) lookup(mk(32'h100 + k, 5, k), 1'b1, "R4 fill invalid");
    read_chk(5, 2, "R8 read full set");

    // hits at different offsets, back to back
    lookup(mk(32'h102, 5, 15), 1'b0, "R2 hit way2");
    lookup(mk(32'h100, 5, 0),  1'b0, "R1 offset ignored hit");
    lookup(mk(32'h103, 5, 7),  1'b0, "R2 hit way3");
    read_chk(5, 1, "R5 lru after hits");

    // replacement via pseudo-LRU
    lookup(mk(32'h104, 5, 0), 1'b1, "R4 victim fill");
    lookup(mk(32'h105, 5, 0), 1'b1, "R4 second victim");
    lookup(mk(32'h106, 5, 0), 1'b1, "R5 third victim");
    read_chk(5, 0, "R5 lru after victims");
    lookup(mk(32'h104, 5, 9), 1'b0, "R2 hit refilled line");

    // same tag different set misses
    lookup(mk(32'h100, 6, 0), 1'b0, "R1 set split");

    // diagnostic staging, write, ignored lru
    read_chk(5, 3, "R8 read before stage");
    diag(2'b00, 0, 0, 32'h1ABCD, 1'b1, 3'b111);
    chk("R6 tag unchanged", 32'(dg_tag_o), 32'(m_tag[5][3]));
    chk("R6 lru unchanged", 32'(dg_lru_o), 32'(m_lru[5]));
    diag(2'b01, 9, 2, 32'h0, 1'b0, 3'b111);
    read_chk(9, 2, "R7 diag write");
    lookup(mk(32'h1ABCD, 9, 4), 1'b0, "R7 hit after diag write");
    diag(2'b01, 9, 0, 32'h0, 1'b0, 3'b101);
    lookup(mk(32'h1ABCD, 9, 4), 1'b0, "R2 duplicate lowest way");
    read_chk(9, 0, "R7 lru only from accesses");

    // concurrent lookup and diagnostic command
    lk_valid_i = 1'b1; lk_addr_i = mk(32'h77, 20, 0); lk_alloc_i = 1'b1;
    diag(2'b10, 20, 0, 0, 1'b0, 3'b000);
    lk_valid_i = 1'b0; lk_alloc_i = 1'b0;
    chk("R10 no response", 32'(rsp_valid_o), 0);
    chk("R10 no fill", 32'(dg_vset_o), 0);
    lookup(mk(32'h77, 20, 0), 1'b0, "R10 still missing");

    // flush
    diag(2'b11, 0, 0, 0, 1'b0, 3'b000);
    read_chk(5, 0, "R9 flush set5");
    read_chk(9, 2, "R9 flush set9");
    lookup(mk(32'h104, 5, 0), 1'b0, "R9 miss after flush");
    lookup(mk(32'h200, 5, 0), 1'b1, "R9 refill way0");

    repeat (3) @(negedge clk);
    chk("R1 all responses seen", 32'(exp_q.size()), 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule